// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This unit sits between the fetch stage and the instruction cache and converts each fetch program counter into a physical address, an uncacheable flag and a fault code. It resolves every request in one pass and presents the result from output registers one clock after the request. The translation storage lives outside: the unit drives the virtual page number and address-space identifier to an attached lookup structure and consumes its hit flag, physical page number and per-mode execute permission mask in the same cycle.

Five routes are resolved in priority order. Privileged code, marked by a set bit 0 in the PC, bypasses all checks. A physical-mode request passes the PC through untranslated. Other addresses must be canonical; a reserved window of the virtual space maps directly to physical memory for kernel mode only. Everything else goes through the lookup result and the permission mask. Addresses from the physical, direct-mapped and looked-up routes then pass a physical range check and a cacheability classification, and instruction fetches from uncached space are refused.

Top module: `ifetch_xlate`

## Requirements
- R1: While rst_n is low and after it is released, rsp_valid is 0, rsp_fault is 0, rsp_uncached is 0 and rsp_paddr is 0 until the first request completes.
- R2: A request with req_valid high at a rising edge produces its result at that edge, with rsp_valid high for one cycle; when req_valid is low, rsp_valid is low and rsp_paddr, rsp_fault and rsp_uncached keep their values.
- R3: When req_pc bit 0 is 1 the result is fault 0 (none), rsp_uncached 0, and rsp_paddr equals req_pc with bits 1:0 cleared and bits 63:44 cleared, regardless of every other input.
- R4: When req_pc bit 0 is 0 and req_phys is 1, the candidate physical address equals req_pc unchanged and goes to the range and cacheability checks (R10 to R12).
- R5: Otherwise, if req_pc bits 63:47 are not all equal, the result is fault 1 (access violation).
- R6: Otherwise, if req_pc bits 47:41 equal 0x7e, the request is direct-mapped: with req_mode not 0 (kernel) the result is fault 1; in kernel mode the candidate is req_pc bits 39:0 with bits 43:40 forced to 1111 when req_pc bit 40 is 1, else zero above bit 39.
- R7: Otherwise, with lk_hit 0 the result is fault 2 (page miss).
- R8: lk_vpn always equals req_pc bits 47:13 and lk_asid equals req_asid; on a hit the candidate is lk_ppn shifted left by 13 combined with req_pc bits 12:2 and two zero bits.
- R9: On a hit the result is fault 1 unless bit req_mode of lk_xmask is 1, with modes encoded 0 kernel, 1 executive, 2 supervisor, 3 user.
- R10: A candidate with any of bits 63:44 set gives fault 3 (machine check).
- R11: A candidate within range with bit 43 set and bits 42:41 equal to 11 (register space) gives fault 4 (unimplemented) with rsp_uncached 0.
- R12: A candidate within range with bit 43 set outside register space gives rsp_uncached 1, rsp_paddr equal to the candidate with bits 42:35 cleared, and fault 4; rsp_uncached is never 1 with another fault code.
- R13: A candidate within range with bit 43 clear gives fault 0, rsp_uncached 0 and rsp_paddr equal to the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_pc | input | 64 | Fetch program counter |
| req_phys | input | 1 | Request is already physical |
| req_mode | input | 2 | Current privilege mode |
| req_asid | input | 8 | Current address-space identifier |
| lk_vpn | output | 35 | Virtual page number sent to the lookup structure |
| lk_asid | output | 8 | Address-space identifier sent to the lookup structure |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_ppn | input | 32 | Physical page number of the matching entry |
| lk_xmask | input | 4 | Execute permission, one bit per mode |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 64 | Physical address |
| rsp_uncached | output | 1 | Access classified uncacheable |
| rsp_fault | output | 3 | Fault code: 0 none, 1 access, 2 miss, 3 machine check, 4 unimplemented |

## Verification
The assertions assume the lookup inputs lk_hit, lk_ppn and lk_xmask are settled in the same cycle as the request they answer, and that req_mode, req_phys and req_pc are held with req_valid at the sampling edge. The bench models the lookup structure as a direct source of those inputs, driving them together with each request half a period before the edge, and builds PCs per route so that direct-mapped, non-canonical, register-space, uncached and out-of-range addresses all occur at useful rates.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ACCESS = 3'd1,
      FLT_MISS   = 3'd2,
      FLT_MCHK   = 3'd3,
      FLT_UNIMP  = 3'd4
   } flt_e;

   typedef enum logic [2:0] {
      ROUTE_PRIV,
      ROUTE_PHYS,
      ROUTE_BADVA,
      ROUTE_DIRECT,
      ROUTE_LOOKUP
   } route_e;

   localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/ifx_route.sv
module ifx_route
   import ifx_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48,
   parameter int DIR_LO  = 41,
   parameter logic [VA_BITS-DIR_LO-1:0] DIR_TAG = '1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              phys,
   output route_e            route
);

   localparam int HI_W = ADDR_W - VA_BITS + 1;

   logic [HI_W-1:0] upper;
   logic            canon;

   assign upper = pc[ADDR_W-1:VA_BITS-1];
   assign canon = (&upper) | ~(|upper);

   always_comb begin
      if (pc[0])
         route = ROUTE_PRIV;
      else if (phys)
         route = ROUTE_PHYS;
      else if (!canon)
         route = ROUTE_BADVA;
      else if (pc[VA_BITS-1:DIR_LO] == DIR_TAG)
         route = ROUTE_DIRECT;
      else
         route = ROUTE_LOOKUP;
   end

endmodule

// File: rtl/ifx_map.sv
module ifx_map
   import ifx_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PA_BITS    = 44,
   parameter int PAGE_SHIFT = 13,
   parameter int PPN_W      = 32,
   parameter int EXT_BIT    = 40,
   parameter bit DIR_EXTEND = 1'b1
) (
   input  route_e             route,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [1:0]         mode,
   input  logic               lk_hit,
   input  logic [PPN_W-1:0]   lk_ppn,
   input  logic [3:0]         lk_xmask,
   output logic [ADDR_W-1:0]  cand,
   output flt_e               early_fault,
   output logic               need_chk
);

   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] IMPL_MASK = (ONE << PA_BITS) - ONE;
   localparam logic [ADDR_W-1:0] LOW_MASK  = (ONE << EXT_BIT) - ONE;
   localparam logic [ADDR_W-1:0] EXT_ONES  = IMPL_MASK & ~LOW_MASK;

   logic [ADDR_W-1:0] dir_pa;
   logic [ADDR_W-1:0] tbl_pa;
   logic [ADDR_W-1:0] priv_pa;

   generate
      if (DIR_EXTEND) begin : g_dir_ext
         assign dir_pa = pc[EXT_BIT] ? ((pc & LOW_MASK) | EXT_ONES)
                                     : (pc & LOW_MASK);
      end else begin : g_dir_plain
         assign dir_pa = pc & IMPL_MASK;
      end
   endgenerate

   assign tbl_pa  = (ADDR_W'(lk_ppn) << PAGE_SHIFT)
                  | ADDR_W'({pc[PAGE_SHIFT-1:2], 2'b00});
   assign priv_pa = {pc[ADDR_W-1:2], 2'b00} & IMPL_MASK;

   always_comb begin
      cand        = '0;
      early_fault = FLT_NONE;
      need_chk    = 1'b0;
      unique case (route)
         ROUTE_PRIV: begin
            cand = priv_pa;
         end
         ROUTE_PHYS: begin
            cand     = pc;
            need_chk = 1'b1;
         end
         ROUTE_BADVA: begin
            early_fault = FLT_ACCESS;
         end
         ROUTE_DIRECT: begin
            if (mode != MODE_KERNEL) begin
               early_fault = FLT_ACCESS;
            end else begin
               cand     = dir_pa;
               need_chk = 1'b1;
            end
         end
         default: begin
            if (!lk_hit) begin
               early_fault = FLT_MISS;
            end else begin
               cand = tbl_pa;
               if (!lk_xmask[mode])
                  early_fault = FLT_ACCESS;
               else
                  need_chk = 1'b1;
            end
         end
      endcase
   end

endmodule

// File: rtl/ifx_classify.sv
module ifx_classify
   import ifx_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int PA_BITS = 44,
   parameter int CLR_HI  = 42,
   parameter int CLR_LO  = 35,
   parameter int REG_HI  = 42,
   parameter int REG_LO  = 41,
   parameter logic [REG_HI-REG_LO:0] REG_TAG = '1
) (
   input  logic [ADDR_W-1:0] cand,
   output logic [ADDR_W-1:0] pa,
   output logic              uncached,
   output flt_e              fault
);

   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] IMPL_MASK = (ONE << PA_BITS) - ONE;
   localparam logic [ADDR_W-1:0] CLR_MASK  =
      ((ONE << (CLR_HI + 1)) - ONE) & ~((ONE << CLR_LO) - ONE);
   localparam int UC_BIT = PA_BITS - 1;

   logic out_of_range;
   logic in_reg_space;

   assign out_of_range = |(cand & ~IMPL_MASK);
   assign in_reg_space = (cand[REG_HI:REG_LO] == REG_TAG);

   always_comb begin
      pa       = cand;
      uncached = 1'b0;
      fault    = FLT_NONE;
      if (out_of_range) begin
         fault = FLT_MCHK;
      end else if (cand[UC_BIT]) begin
         fault = FLT_UNIMP;
         if (!in_reg_space) begin
            uncached = 1'b1;
            pa       = cand & ~CLR_MASK;
         end
      end
   end

endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
   import ifx_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int VA_BITS    = 48,
   parameter int PA_BITS    = 44,
   parameter int PAGE_SHIFT = 13,
   parameter int PPN_W      = 32,
   parameter int ASID_W     = 8,
   parameter int DIR_LO     = 41,
   parameter logic [VA_BITS-DIR_LO-1:0] DIR_TAG = 7'h7e,
   parameter int EXT_BIT    = 40,
   parameter bit DIR_EXTEND = 1'b1,
   parameter int CLR_HI     = 42,
   parameter int CLR_LO     = 35,
   parameter int REG_HI     = 42,
   parameter int REG_LO     = 41,
   parameter logic [REG_HI-REG_LO:0] REG_TAG = 2'b11,
   localparam int VPN_W     = VA_BITS - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic              req_phys,
   input  logic [1:0]        req_mode,
   input  logic [ASID_W-1:0] req_asid,
   output logic [VPN_W-1:0]  lk_vpn,
   output logic [ASID_W-1:0] lk_asid,
   input  logic              lk_hit,
   input  logic [PPN_W-1:0]  lk_ppn,
   input  logic [3:0]        lk_xmask,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_uncached,
   output logic [2:0]        rsp_fault
);

   generate
      if (PA_BITS >= ADDR_W || VA_BITS > ADDR_W) begin : g_bad_widths
         $error("ifetch_xlate: address widths out of range");
      end
      if (EXT_BIT >= PA_BITS || CLR_HI >= PA_BITS - 1 || CLR_LO > CLR_HI) begin : g_bad_fields
         $error("ifetch_xlate: field positions out of range");
      end
      if (DIR_LO >= VA_BITS || PAGE_SHIFT < 3) begin : g_bad_split
         $error("ifetch_xlate: page or window split out of range");
      end
   endgenerate

   route_e            route;
   logic [ADDR_W-1:0] cand;
   flt_e              early_fault;
   logic              need_chk;
   logic [ADDR_W-1:0] cls_pa;
   logic              cls_uc;
   flt_e              cls_fault;

   logic [ADDR_W-1:0] pa_d;
   logic              uc_d;
   flt_e              fault_d;

   logic [ADDR_W-1:0] pa_q;
   logic              uc_q;
   flt_e              fault_q;
   logic              vld_q;

   assign lk_vpn  = req_pc[VA_BITS-1:PAGE_SHIFT];
   assign lk_asid = req_asid;

   ifx_route #(
      .ADDR_W (ADDR_W),
      .VA_BITS(VA_BITS),
      .DIR_LO (DIR_LO),
      .DIR_TAG(DIR_TAG)
   ) u_route (
      .pc   (req_pc),
      .phys (req_phys),
      .route(route)
   );

   ifx_map #(
      .ADDR_W    (ADDR_W),
      .PA_BITS   (PA_BITS),
      .PAGE_SHIFT(PAGE_SHIFT),
      .PPN_W     (PPN_W),
      .EXT_BIT   (EXT_BIT),
      .DIR_EXTEND(DIR_EXTEND)
   ) u_map (
      .route      (route),
      .pc         (req_pc),
      .mode       (req_mode),
      .lk_hit     (lk_hit),
      .lk_ppn     (lk_ppn),
      .lk_xmask   (lk_xmask),
      .cand       (cand),
      .early_fault(early_fault),
      .need_chk   (need_chk)
   );

   ifx_classify #(
      .ADDR_W (ADDR_W),
      .PA_BITS(PA_BITS),
      .CLR_HI (CLR_HI),
      .CLR_LO (CLR_LO),
      .REG_HI (REG_HI),
      .REG_LO (REG_LO),
      .REG_TAG(REG_TAG)
   ) u_classify (
      .cand    (cand),
      .pa      (cls_pa),
      .uncached(cls_uc),
      .fault   (cls_fault)
   );

   always_comb begin
      if (need_chk) begin
         pa_d    = cls_pa;
         uc_d    = cls_uc;
         fault_d = cls_fault;
      end else begin
         pa_d    = cand;
         uc_d    = 1'b0;
         fault_d = early_fault;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         pa_q    <= '0;
         uc_q    <= 1'b0;
         fault_q <= FLT_NONE;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            pa_q    <= pa_d;
            uc_q    <= uc_d;
            fault_q <= fault_d;
         end
      end
   end

   assign rsp_valid    = vld_q;
   assign rsp_paddr    = pa_q;
   assign rsp_uncached = uc_q;
   assign rsp_fault    = fault_q;

endmodule

// File: rtl/ifetch_xlate_chk.sv
module ifetch_xlate_chk #(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48,
   parameter int PA_BITS = 44,
   parameter int DIR_LO  = 41,
   parameter logic [VA_BITS-DIR_LO-1:0] DIR_TAG = 7'h7e,
   parameter int CLR_HI  = 42,
   parameter int CLR_LO  = 35
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_pc,
   input logic              req_phys,
   input logic [1:0]        req_mode,
   input logic              lk_hit,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              rsp_uncached,
   input logic [2:0]        rsp_fault
);

   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] IMPL_MASK = (ONE << PA_BITS) - ONE;

   logic canon_va;
   logic on_table_route;
   assign canon_va = (&req_pc[ADDR_W-1:VA_BITS-1]) | ~(|req_pc[ADDR_W-1:VA_BITS-1]);
   assign on_table_route = req_valid && !req_pc[0] && !req_phys && canon_va;

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_uncached)));

   a_r3_priv_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pc[0]) |=> (rsp_fault == 3'd0 && !rsp_uncached && rsp_paddr[1:0] == 2'b00));

   a_r6_direct_user: assert property (@(posedge clk) disable iff (!rst_n)
      (on_table_route && req_pc[VA_BITS-1:DIR_LO] == DIR_TAG && req_mode != 2'd0)
      |=> rsp_fault == 3'd1);

   a_r7_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (on_table_route && req_pc[VA_BITS-1:DIR_LO] != DIR_TAG && !lk_hit)
      |=> rsp_fault == 3'd2);

   a_r10_clean_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd0) |-> (rsp_paddr & ~IMPL_MASK) == '0);

   a_r12_uncached_shape: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncached |-> (rsp_fault == 3'd4 && rsp_paddr[CLR_HI:CLR_LO] == '0
                        && rsp_paddr[PA_BITS-1]));

endmodule

bind ifetch_xlate ifetch_xlate_chk #(
   .ADDR_W (ADDR_W),
   .VA_BITS(VA_BITS),
   .PA_BITS(PA_BITS),
   .DIR_LO (DIR_LO),
   .DIR_TAG(DIR_TAG),
   .CLR_HI (CLR_HI),
   .CLR_LO (CLR_LO)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_pc      (req_pc),
   .req_phys    (req_phys),
   .req_mode    (req_mode),
   .lk_hit      (lk_hit),
   .rsp_valid   (rsp_valid),
   .rsp_paddr   (rsp_paddr),
   .rsp_uncached(rsp_uncached),
   .rsp_fault   (rsp_fault)
);

// File: tb/ifetch_xlate_bench.sv
`timescale 1ns/1ps
module ifetch_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_pc = '0;
   logic        req_phys = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [7:0]  req_asid = '0;
   logic [34:0] lk_vpn;
   logic [7:0]  lk_asid;
   logic        lk_hit = 1'b0;
   logic [31:0] lk_ppn = '0;
   logic [3:0]  lk_xmask = '0;
   logic        rsp_valid;
   logic [63:0] rsp_paddr;
   logic        rsp_uncached;
   logic [2:0]  rsp_fault;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ifetch_xlate u_ifetch_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
      .req_phys(req_phys), .req_mode(req_mode), .req_asid(req_asid),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .lk_xmask(lk_xmask), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic void model(input logic [63:0] pc, input logic phys, input logic [1:0] mode,
                                 input logic hit, input logic [31:0] ppn, input logic [3:0] xm,
                                 output logic [63:0] pa, output logic uc, output logic [2:0] f,
                                 output string tag);
      logic [63:0] p;
      logic go;
      pa = '0; uc = 1'b0; f = 3'd0; go = 1'b0; p = '0; tag = "R13";
      if (pc[0]) begin
         pa = {20'h0, pc[43:2], 2'b00}; tag = "R3";              // R3
      end else if (phys) begin
         p = pc; go = 1'b1; tag = "R4";                          // R4
      end else if (!((&pc[63:47]) || !(|pc[63:47]))) begin
         f = 3'd1; tag = "R5";                                   // R5
      end else if (pc[47:41] == 7'h7e) begin
         tag = "R6";                                             // R6
         if (mode != 2'd0) f = 3'd1;
         else begin
            p = pc[40] ? {20'h0, 4'hf, pc[39:0]} : {24'h0, pc[39:0]};
            go = 1'b1;
         end
      end else if (!hit) begin
         f = 3'd2; tag = "R7";                                   // R7
      end else begin
         p = ({32'h0, ppn} << 13) | {51'h0, pc[12:2], 2'b00};
         tag = "R8";                                             // R8
         if (!xm[mode]) begin f = 3'd1; tag = "R9"; end          // R9
         else go = 1'b1;
      end
      if (go) begin
         pa = p;
         if (p[63:44] != 0) begin f = 3'd3; tag = {tag, "/R10"}; end
         else if (p[43]) begin
            f = 3'd4;
            if (p[42:41] == 2'b11) tag = {tag, "/R11"};
            else begin uc = 1'b1; pa = p & ~64'h0000_07f8_0000_0000; tag = {tag, "/R12"}; end
         end else tag = {tag, "/R13"};
      end
   endfunction

   // Drive at a falling edge, result appears at the next falling edge
   task automatic run(input logic [63:0] pc, input logic phys, input logic [1:0] mode,
                      input logic hit, input logic [31:0] ppn, input logic [3:0] xm,
                      input logic [7:0] asid);
      logic [63:0] epa; logic euc; logic [2:0] ef; string tag;
      req_valid = 1'b1; req_pc = pc; req_phys = phys; req_mode = mode;
      lk_hit = hit; lk_ppn = ppn; lk_xmask = xm; req_asid = asid;
      #1;
      check("R8 lookup vpn", 64'(lk_vpn), 64'(pc[47:13]));
      check("R8 lookup asid", 64'(lk_asid), 64'(asid));
      model(pc, phys, mode, hit, ppn, xm, epa, euc, ef, tag);
      @(negedge clk);
      check({"R2 valid ", tag}, 64'(rsp_valid), 64'd1);
      check({tag, " fault"}, 64'(rsp_fault), 64'(ef));
      check({tag, " uncached"}, 64'(rsp_uncached), 64'(euc));
      if (ef == 3'd0 || ef == 3'd4)
         check({tag, " paddr"}, rsp_paddr, epa);
   endtask

   task automatic idle_check(input logic [63:0] pc);
      logic [63:0] pa0; logic [2:0] f0; logic uc0;
      pa0 = rsp_paddr; f0 = rsp_fault; uc0 = rsp_uncached;
      req_valid = 1'b0; req_pc = pc; req_phys = 1'b1; lk_hit = 1'b1;
      @(negedge clk);
      check("R2 idle valid", 64'(rsp_valid), 64'd0);
      check("R2 idle paddr", rsp_paddr, pa0);
      check("R2 idle fault", 64'(rsp_fault), 64'(f0));
      check("R2 idle uncached", 64'(rsp_uncached), 64'(uc0));
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL R2 watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4242));
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1 valid", 64'(rsp_valid), 64'd0);
      check("R1 fault", 64'(rsp_fault), 64'd0);
      check("R1 uncached", 64'(rsp_uncached), 64'd0);
      check("R1 paddr", rsp_paddr, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 64'(rsp_valid), 64'd0);

      // Directed corners
      run(64'hffff_ffff_ffff_ffff, 1'b1, 2'd3, 1'b0, 32'h0, 4'h0, 8'h11); // R3 all ones
      run(64'h0000_0000_1234_5673, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 8'h12); // R3
      run(64'h0000_0012_3456_7006, 1'b1, 2'd3, 1'b0, 32'h0, 4'h0, 8'h13); // R4/R13
      run(64'h0010_0000_0000_0000, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0, 8'h14); // R10
      run(64'h0000_0e00_0000_1000, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0, 8'h15); // R11
      run(64'h0000_0aff_0000_2000, 1'b1, 2'd0, 1'b0, 32'h0, 4'h0, 8'h16); // R12
      run(64'h0001_0000_0000_0000, 1'b0, 2'd0, 1'b1, 32'h1, 4'hf, 8'h17); // R5
      run(64'hffff_fc12_3456_7000, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 8'h18); // R6 bit40 clear
      run(64'hffff_fd12_3456_7000, 1'b0, 2'd0, 1'b0, 32'h0, 4'h0, 8'h19); // R6 bit40 set
      run(64'hffff_fc12_3456_7000, 1'b0, 2'd1, 1'b1, 32'h5, 4'hf, 8'h1a); // R6 non-kernel
      run(64'h0000_0000_0040_2abc, 1'b0, 2'd0, 1'b0, 32'h9, 4'hf, 8'h1b); // R7
      for (int m = 0; m < 4; m++) begin                                   // R9 per mode
         run(64'h0000_0000_0040_2abc, 1'b0, 2'(m), 1'b1, 32'h123, 4'(1 << m), 8'h20);
         run(64'h0000_0000_0040_2abc, 1'b0, 2'(m), 1'b1, 32'h123, ~4'(1 << m), 8'h21);
      end
      run(64'h0000_0000_0040_2abc, 1'b0, 2'd0, 1'b1, 32'h4000_0001, 4'h1, 8'h22); // R12 via hit
      run(64'h0000_0000_0040_2abc, 1'b0, 2'd0, 1'b1, 32'h8000_0000, 4'h1, 8'h23); // R10 via hit
      idle_check(64'h0000_0000_0000_0001);                                // R2
      idle_check(64'h0010_0000_0000_0000);                                // R2

      // Constrained random
      for (int i = 0; i < 1500; i++) begin
         logic [63:0] pc; logic ph; logic [31:0] ppn; logic hit;
         int cat; int sel;
         cat = int'($urandom % 8);
         sel = int'($urandom % 4);
         pc = rnd64(); ph = 1'b0; hit = ($urandom % 5) != 0;
         ppn = $urandom;
         case (sel)
            0: ppn = ppn & 32'h3fff_ffff;
            1: ppn = ppn & 32'h7fff_ffff;
            2: ppn = (ppn & 32'h4fff_ffff) | 32'h4000_0000;
            default: ;
         endcase
         case (cat)
            0: pc[0] = 1'b1;
            1: begin
               ph = 1'b1; pc[0] = 1'b0;
               if (sel != 3) pc[63:44] = '0;
               if (sel == 1) pc[43] = 1'b1;
            end
            2: begin
               pc[0] = 1'b0;
               if (pc[63:47] == '0 || pc[63:47] == '1) pc[52] = ~pc[52];
            end
            3: pc = {16'hffff, 7'h7e, pc[40:1], 1'b0};
            default: begin
               pc = {{16{pc[47]}}, pc[47:1], 1'b0};
               if (pc[47:41] == 7'h7e) pc[41] = 1'b1;
            end
         endcase
         run(pc, ph, 2'($urandom), hit, ppn, 4'($urandom), 8'($urandom));
         if (($urandom % 16) == 0) idle_check(rnd64());
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule